// File: doc/BRIEF.md
# Cache Line Error Triage Unit

This unit sits beside a cache whose contents are guarded by a single-error-correct, double-error-detect code. Each time the code checker flags a read, it reports the failing location (set and way) and whether the damage was one bit or more than one bit. The unit turns every report into a repair action. A single-bit error seen for the first time is treated as transient, and the line is purged so that the cell is rewritten with fresh data. A second single-bit error on the same location shortly afterwards marks a stuck cell, and the line is retired for good. Multi-bit damage is both purged and retired, and firmware is told to take the attached core out of service.

A four-entry recency table holds the locations of recent single-bit errors. An entry lives for a programmable number of cycles after its purge. When the table is full, a new entry replaces the one touched longest ago. Retired lines are kept as one bit per set and way. The replacement logic reads them through a combinational lookup port and never allocates a retired way. Retiring the final usable way of a set is never allowed: that delete is dropped and firmware is alerted. Repair commands wait in a two-entry queue. When the queue is full, the error-report port is stalled.

Top module: `cache_fault_triage`

## Requirements
- R1: After reset, cmdValid and fwAlert are 0, rptReady is 1 and lkMask is all zeros for every set.
- R2: A single-bit report (rptMulti=0) whose location is not held in the recency table issues one command with cmdOp=2'b01 (bit 0 = purge, bit 1 = delete) for that set and way, and records the location in the table.
- R3: A single-bit report for a location that was recorded 1 to `window` cycles earlier (counted between accepting clock edges) is hard. It issues cmdOp=2'b10 and sets that location's delete bit.
- R4: A single-bit report that arrives more than `window` cycles after the location was recorded finds no entry. It is handled as in R2.
- R5: A multi-bit report issues cmdOp=2'b11 and sets the delete bit. In the cycle after acceptance it raises fwAlert for one cycle with fwReason=1 (core deconfigure).
- R6: A delete that would leave every way of a set retired is refused and the delete bit stays clear. For a hard single-bit error, no command is issued, and fwAlert pulses with fwReason=0 (last way kept). For a multi-bit error, the command is cmdOp=2'b01 and fwAlert pulses with fwReason=1.
- R7: The recency table holds four locations. A fifth distinct location evicts the location that was recorded longest ago, and the other three still classify as hard.
- R8: Commands leave in report order through a two-entry queue. rptReady is 0 while two commands are waiting. A stalled command holds cmdOp, cmdSet and cmdWay steady.
- R9: lkMask shows, combinationally, the delete bits of set lkSet (bit w = way w retired). A new delete bit appears on the clock edge that accepts the report.
- R10: A hard classification frees its table entry. The next single-bit report on that location is again handled as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| window | input | WIN_W | Hard-error window in cycles (at least 1) |
| rptValid | input | 1 | Error report present |
| rptReady | output | 1 | Report accepted on this edge when both are high |
| rptMulti | input | 1 | 1 = multi-bit error, 0 = single-bit |
| rptSet | input | SET_W | Set of the failing line |
| rptWay | input | WAY_W | Way of the failing line |
| cmdValid | output | 1 | Repair command present |
| cmdReady | input | 1 | Cache accepts the command |
| cmdOp | output | 2 | bit 0 purge, bit 1 delete |
| cmdSet | output | SET_W | Command set |
| cmdWay | output | WAY_W | Command way |
| lkSet | input | SET_W | Set queried by replacement logic |
| lkMask | output | WAYS | Retired ways of lkSet |
| fwAlert | output | 1 | One-cycle firmware alert |
| fwReason | output | 1 | 1 = deconfigure core, 0 = last-way delete refused |

## Verification
Two functions can fall in the same cycle: accepting a report, which pushes a command, and the cache taking the head command, which pops it. The bench holds cmdReady low until two commands are waiting and checks that rptReady drops and that the head stays put. It then releases cmdReady while a third report is pending, so that pop and push share edges. A scoreboard judges the outcome: every command must arrive once, in report order, with the right operation. A second contest is between the window expiring and a report on the same location. Reports spaced exactly `window` and `window`+1 cycles after the purge must give delete and purge respectively.

// File: rtl/cft_pkg.sv
package cft_pkg;
  // strobes from classification control to datapath
  typedef struct packed {
    logic push;      // enqueue a repair command
    logic purge;     // command carries purge
    logic delete;    // command carries delete, set retire bit
    logic alert;     // pulse firmware alert
    logic alertCore; // alert means core deconfigure
  } strobe_t;
endpackage

// File: rtl/cft_ctrl.sv
module cft_ctrl
  import cft_pkg::*;
#(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int ENTRIES = 4,
  parameter int WIN_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] window,
  input  logic             rptValid,
  input  logic             rptMulti,
  input  logic [SET_W-1:0] rptSet,
  input  logic [WAY_W-1:0] rptWay,
  input  logic             fifoFull,
  input  logic [WAYS-1:0]  setMask,
  output logic             rptReady,
  output strobe_t          strb
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [WIN_W:0] AGE_ONE = 1;

  logic             entValid [ENTRIES];
  logic [SET_W-1:0] entSet   [ENTRIES];
  logic [WAY_W-1:0] entWay   [ENTRIES];
  logic [WIN_W-1:0] entAge   [ENTRIES];
  logic [IDX_W-1:0] entRank  [ENTRIES];

  logic             accept;
  logic             anyHit;
  logic [IDX_W-1:0] hitIdx;
  logic             haveFree;
  logic [IDX_W-1:0] victim;
  logic [WAYS-1:0]  wayBit;
  logic             lastWay;

  assign rptReady = !fifoFull;
  assign accept   = rptValid && !fifoFull;
  assign wayBit   = WAYS'(1) << rptWay;
  assign lastWay  = (&(setMask | wayBit)) && !setMask[rptWay];

  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (entValid[i] && entSet[i] == rptSet && entWay[i] == rptWay) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    haveFree = 1'b0;
    victim   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!entValid[i] && !haveFree) begin
        haveFree = 1'b1;
        victim   = IDX_W'(i);
      end
    end
    if (!haveFree) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (entRank[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strb = '0;
    if (accept) begin
      if (rptMulti) begin
        strb.push      = 1'b1;
        strb.purge     = 1'b1;
        strb.delete    = !lastWay;
        strb.alert     = 1'b1;
        strb.alertCore = 1'b1;
      end else if (anyHit) begin
        if (lastWay) begin
          strb.alert = 1'b1;
        end else begin
          strb.push   = 1'b1;
          strb.delete = 1'b1;
        end
      end else begin
        strb.push  = 1'b1;
        strb.purge = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entValid[i] <= 1'b0;
        entSet[i]   <= '0;
        entWay[i]   <= '0;
        entAge[i]   <= '0;
        entRank[i]  <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (entValid[i]) begin
          if (({1'b0, entAge[i]} + AGE_ONE) >= {1'b0, window}) entValid[i] <= 1'b0;
          else entAge[i] <= entAge[i] + 1'b1;
        end
      end
      if (accept && !rptMulti) begin
        if (anyHit) begin
          entValid[hitIdx] <= 1'b0;
        end else begin
          entValid[victim] <= 1'b1;
          entSet[victim]   <= rptSet;
          entWay[victim]   <= rptWay;
          entAge[victim]   <= '0;
          for (int j = 0; j < ENTRIES; j++) begin
            if (IDX_W'(j) == victim) entRank[j] <= '0;
            else if (entRank[j] < entRank[victim]) entRank[j] <= entRank[j] + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cft_data.sv
module cft_data
  import cft_pkg::*;
#(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int DEPTH = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [SET_W-1:0] rptSet,
  input  logic [WAY_W-1:0] rptWay,
  input  logic             cmdReady,
  input  logic [SET_W-1:0] lkSet,
  output logic             fifoFull,
  output logic [WAYS-1:0]  setMask,
  output logic             cmdValid,
  output logic [1:0]       cmdOp,
  output logic [SET_W-1:0] cmdSet,
  output logic [WAY_W-1:0] cmdWay,
  output logic [WAYS-1:0]  lkMask,
  output logic             fwAlert,
  output logic             fwReason
);
  localparam int ENT_W = 2 + SET_W + WAY_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WAYS-1:0]  delBits [SETS];
  logic [ENT_W-1:0] queue   [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  // retired-line bits, one register row per set
  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) delBits[s] <= '0;
      else if (strb.delete && rptSet == SET_W'(s)) delBits[s][rptWay] <= 1'b1;
    end
  end

  assign setMask = delBits[rptSet];
  assign lkMask  = delBits[lkSet];

  assign fifoFull = (count == CNT_W'(DEPTH));
  assign cmdValid = (count != '0);
  assign pop      = cmdValid && cmdReady;
  assign {cmdOp, cmdSet, cmdWay} = queue[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.push) queue[wrPtr] <= {strb.delete, strb.purge, rptSet, rptWay};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      fwAlert  <= 1'b0;
      fwReason <= 1'b0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (pop) rdPtr <= nextPtr(rdPtr);
      count    <= count + CNT_W'(strb.push) - CNT_W'(pop);
      fwAlert  <= strb.alert;
      fwReason <= strb.alertCore;
    end
  end
endmodule

// File: rtl/cache_fault_triage.sv
module cache_fault_triage
  import cft_pkg::*;
#(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int ENTRIES = 4,
  parameter int DEPTH = 2,
  parameter int WIN_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] window,
  input  logic             rptValid,
  output logic             rptReady,
  input  logic             rptMulti,
  input  logic [SET_W-1:0] rptSet,
  input  logic [WAY_W-1:0] rptWay,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic [1:0]       cmdOp,
  output logic [SET_W-1:0] cmdSet,
  output logic [WAY_W-1:0] cmdWay,
  input  logic [SET_W-1:0] lkSet,
  output logic [WAYS-1:0]  lkMask,
  output logic             fwAlert,
  output logic             fwReason
);
  strobe_t         strb;
  logic            fifoFull;
  logic [WAYS-1:0] setMask;

  cft_ctrl #(.SETS(SETS), .WAYS(WAYS), .ENTRIES(ENTRIES), .WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rst(rst), .window(window), .rptValid(rptValid),
    .rptMulti(rptMulti), .rptSet(rptSet), .rptWay(rptWay),
    .fifoFull(fifoFull), .setMask(setMask), .rptReady(rptReady), .strb(strb)
  );

  cft_data #(.SETS(SETS), .WAYS(WAYS), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .rptSet(rptSet), .rptWay(rptWay),
    .cmdReady(cmdReady), .lkSet(lkSet), .fifoFull(fifoFull), .setMask(setMask),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSet(cmdSet), .cmdWay(cmdWay),
    .lkMask(lkMask), .fwAlert(fwAlert), .fwReason(fwReason)
  );
endmodule

// File: rtl/cft_checker.sv
module cft_checker #(
  parameter int WAYS = 4,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             rptValid,
  input logic             rptReady,
  input logic             rptMulti,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [1:0]       cmdOp,
  input logic [SET_W-1:0] cmdSet,
  input logic [WAY_W-1:0] cmdWay,
  input logic [WAYS-1:0]  lkMask,
  input logic             fwAlert,
  input logic             fwReason,
  input logic             pushStrobe,
  input logic             fifoFull
);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    pushStrobe |-> !fifoFull);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable({cmdOp, cmdSet, cmdWay})));

  // R5
  multi_alert_chk: assert property (@(posedge clk) disable iff (rst)
    (rptValid && rptReady && rptMulti) |=> (fwAlert && fwReason));

  // R6
  last_way_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !(&lkMask));

  // R2
  single_no_deconfig_chk: assert property (@(posedge clk) disable iff (rst)
    (rptValid && rptReady && !rptMulti) |=> !(fwAlert && fwReason));
endmodule

bind cache_fault_triage cft_checker #(.WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst(rst), .rptValid(rptValid), .rptReady(rptReady), .rptMulti(rptMulti),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdSet(cmdSet),
  .cmdWay(cmdWay), .lkMask(lkMask), .fwAlert(fwAlert), .fwReason(fwReason),
  .pushStrobe(strb.push), .fifoFull(fifoFull)
);

// File: tb/sim_cache_fault_triage.sv
`timescale 1ns/1ps
module sim_cache_fault_triage;
  localparam int W = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] window = 8'(W);
  logic       rptValid = 1'b0, rptMulti = 1'b0;
  logic [2:0] rptSet = '0;
  logic [1:0] rptWay = '0;
  logic       rptReady, cmdValid, fwAlert, fwReason;
  logic       cmdReady = 1'b1;
  logic [1:0] cmdOp;
  logic [2:0] cmdSet;
  logic [1:0] cmdWay;
  logic [2:0] lkSet = '0;
  logic [3:0] lkMask;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [6:0] cmdQ[$];
  string      cmdTag[$];
  logic       alrQ[$];
  string      alrTag[$];

  always #2.5 clk = ~clk;

  cache_fault_triage u0 (
    .clk(clk), .rst(rst), .window(window), .rptValid(rptValid), .rptReady(rptReady),
    .rptMulti(rptMulti), .rptSet(rptSet), .rptWay(rptWay), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdSet(cmdSet), .cmdWay(cmdWay),
    .lkSet(lkSet), .lkMask(lkMask), .fwAlert(fwAlert), .fwReason(fwReason)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expCmd(input logic [1:0] op, input int s, input int w, input string tag);
    cmdQ.push_back({op, 3'(s), 2'(w)});
    cmdTag.push_back(tag);
  endtask

  task automatic expAlert(input logic reason, input string tag);
    alrQ.push_back(reason);
    alrTag.push_back(tag);
  endtask

  task automatic send(input logic m, input int s, input int w);
    @(negedge clk);
    rptValid = 1'b1; rptMulti = m; rptSet = 3'(s); rptWay = 2'(w);
    while (!rptReady) @(negedge clk);
    @(posedge clk);
    #1 rptValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(input int s, input logic [3:0] exp, input string tag);
    lkSet = 3'(s);
    #0.5 chk(lkMask == exp, tag, lkMask, exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cmdValid && cmdReady) begin
        if (cmdQ.size() == 0) begin
          chk(1'b0, "R6/R8 unexpected command", {cmdOp, cmdSet, cmdWay}, 0);
        end else begin
          automatic logic [6:0] e = cmdQ.pop_front();
          automatic string t = cmdTag.pop_front();
          chk({cmdOp, cmdSet, cmdWay} == e, t, {cmdOp, cmdSet, cmdWay}, e);
        end
      end
      if (fwAlert) begin
        if (alrQ.size() == 0) begin
          chk(1'b0, "R5/R6 unexpected alert", fwReason, 0);
        end else begin
          automatic logic e = alrQ.pop_front();
          automatic string t = alrTag.pop_front();
          chk(fwReason == e, t, fwReason, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    #0.5;
    // R1 reset state
    chk(cmdValid == 1'b0, "R1 cmdValid", cmdValid, 0);
    chk(rptReady == 1'b1, "R1 rptReady", rptReady, 1);
    chk(fwAlert == 1'b0, "R1 fwAlert", fwAlert, 0);
    look(1, 4'b0000, "R1 lkMask");

    // R2 soft error -> purge
    expCmd(2'b01, 1, 2, "R2 soft purge");
    send(0, 1, 2);
    // R3 repeat within window -> delete
    idle(2);
    expCmd(2'b10, 1, 2, "R3 hard delete");
    send(0, 1, 2);
    look(1, 4'b0100, "R9 delete bit visible");
    // R10 entry freed -> soft again
    expCmd(2'b01, 1, 2, "R10 purge after hard");
    send(0, 1, 2);

    // R3 boundary: exactly W cycles -> hard
    expCmd(2'b01, 3, 1, "R2 purge");
    send(0, 3, 1);
    idle(W - 1);
    expCmd(2'b10, 3, 1, "R3 hard at window edge");
    send(0, 3, 1);
    // R4 W+1 cycles -> soft
    expCmd(2'b01, 3, 0, "R2 purge");
    send(0, 3, 0);
    idle(W);
    expCmd(2'b01, 3, 0, "R4 window expired purge");
    send(0, 3, 0);
    look(3, 4'b0010, "R9 set 3 mask");

    // R5 multi-bit
    expCmd(2'b11, 4, 3, "R5 multi purge+delete");
    expAlert(1'b1, "R5 deconfigure alert");
    send(1, 4, 3);
    look(4, 4'b1000, "R5 delete bit");

    // R6 last way protection in set 5
    for (int w = 0; w < 3; w++) begin
      expCmd(2'b01, 5, w, "R6 setup purge");
      send(0, 5, w);
      expCmd(2'b10, 5, w, "R6 setup delete");
      send(0, 5, w);
    end
    expCmd(2'b01, 5, 3, "R6 last way purge");
    send(0, 5, 3);
    expAlert(1'b0, "R6 last-way alert");
    send(0, 5, 3);
    idle(2);
    look(5, 4'b0111, "R6 last way kept");
    expCmd(2'b01, 5, 3, "R6 multi on last way purge only");
    expAlert(1'b1, "R6 multi alert");
    send(1, 5, 3);
    idle(2);
    look(5, 4'b0111, "R6 last way kept after multi");

    // R7 LRU eviction
    idle(W + 2);
    expCmd(2'b01, 0, 0, "R7 fill A");
    send(0, 0, 0);
    expCmd(2'b01, 0, 1, "R7 fill B");
    send(0, 0, 1);
    expCmd(2'b01, 2, 0, "R7 fill C");
    send(0, 2, 0);
    expCmd(2'b01, 2, 1, "R7 fill D");
    send(0, 2, 1);
    expCmd(2'b01, 6, 0, "R7 fill E evicts A");
    send(0, 6, 0);
    expCmd(2'b10, 2, 0, "R7 C retained hard");
    send(0, 2, 0);
    expCmd(2'b01, 0, 0, "R7 A evicted soft");
    send(0, 0, 0);

    // R8 queue full back-pressure
    idle(W + 2);
    cmdReady = 1'b0;
    expCmd(2'b01, 6, 1, "R8 order first");
    send(0, 6, 1);
    expCmd(2'b01, 6, 2, "R8 order second");
    send(0, 6, 2);
    idle(3);
    #0.5;
    chk(rptReady == 1'b0, "R8 rptReady low when full", rptReady, 0);
    chk(cmdValid == 1'b1, "R8 cmdValid held", cmdValid, 1);
    chk({cmdSet, cmdWay} == {3'd6, 2'd1}, "R8 head steady", {cmdSet, cmdWay}, {3'd6, 2'd1});
    expCmd(2'b01, 6, 3, "R8 order third");
    fork
      send(0, 6, 3);
      begin idle(2); cmdReady = 1'b1; end
    join
    idle(10);
    chk(cmdQ.size() == 0, "R8 all commands delivered", cmdQ.size(), 0);
    chk(alrQ.size() == 0, "R6 all alerts seen", alrQ.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule